// File: doc/BRIEF.md
# Variable Pulse Width Symbol Receiver

This block receives frames from a variable-pulse-width serial bus. It samples the line from an external transceiver, removes short noise spikes with a digital filter, and measures how long every active and every passive level lasts. A free-running 1 µs strobe (`tickUs`) is the time base. Each completed level is classified by its width: a data bit, a start-of-frame, an end-of-data, an end-of-frame, or an invalid symbol. Data bits between a start-of-frame and the next end-of-data are packed into bytes, most significant bit first.

A finished byte first goes into a one-byte holding buffer. From there it moves into the receive register, which the host sees on `rxData`, qualified by `rxValid`. A one-cycle pulse on `rdStrobe` consumes the register. An 8-bit CRC runs over every received bit. It is judged when the frame's data ends. Three sticky error flags report invalid pulse timing, a bad checksum, and an end-of-data that arrives partway through a byte. A one-cycle `frameEnd` pulse marks the idle gap that closes a message.

Top module: `vpw_rx`

## Requirements
- R1: A level change on `rxLine` that lasts fewer than 8 `tickUs` strobes is ignored. The pulse it interrupts is measured as if the spike had not occurred.
- R2: An active pulse of 35..96 µs is data bit 1, and one of 97..163 µs is data bit 0. A passive pulse of 35..96 µs is data bit 0, and one of 97..163 µs is data bit 1. Each byte is assembled most significant bit first. Active is `rxLine` = 1.
- R3: An active pulse of 164..239 µs is a start-of-frame. It opens a frame, restarts byte assembly and the CRC, and clears all three error flags. Data bits seen outside an open frame produce no byte.
- R4: Any pulse of 8..34 µs, and any active pulse longer than 239 µs, sets `symErrFlag` and closes the open frame.
- R5: A passive level that reaches 164 µs is an end-of-data and closes the frame. Later data bits produce no byte until the next start-of-frame.
- R6: A passive level that reaches 240 µs gives exactly one single-cycle pulse on `frameEnd`.
- R7: The CRC uses polynomial x^8+x^4+x^3+x^2+1 and starts at FFh. It shifts each bit in most significant bit first and covers every data bit of the frame, including the checksum byte. At a byte-aligned end-of-data, a remainder other than C4h sets `crcErrFlag`.
- R8: An end-of-data that arrives with a partial byte sets `frameErrFlag`, discards the partial byte, and skips the CRC judgement.
- R9: Every completed byte reaches `rxData` in arrival order, through the holding buffer and then the receive register. `rxValid` = 1 marks a byte waiting. An `rdStrobe` while `rxValid` = 1 moves the buffered byte in, or empties the register. No byte is lost or repeated when a read and a byte completion fall in the same cycle.
- R10: After reset, `rxValid`, all error flags and `frameEnd` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tickUs | input | 1 | One-cycle strobe every microsecond |
| rxLine | input | 1 | Receive line from the transceiver, 1 = active |
| rdStrobe | input | 1 | Consume the receive register |
| rxData | output | 8 | Receive register contents |
| rxValid | output | 1 | Receive register holds an unread byte |
| symErrFlag | output | 1 | Sticky symbol timing error |
| crcErrFlag | output | 1 | Sticky checksum error |
| frameErrFlag | output | 1 | Sticky end-of-data inside a byte |
| frameEnd | output | 1 | Pulse at the end-of-frame gap |

## Verification
The collision that matters is a host read of the receive register landing on the same clock edge that a newly completed byte enters the holding buffer. Here the buffer is emptied and refilled at once. To provoke it, the bench leaves the first byte of a two-byte frame unread. It then releases the reader a chosen number of cycles after the raw edge that ends the second byte, and sweeps that delay across the window where the filtered edge, the strobe register and the buffer write line up. A run passes only if the reader gets exactly both bytes, in order, with nothing left in the expected queue.

// File: rtl/vpw_rx_pkg.sv
package vpw_rx_pkg;
  // Events passed from the symbol timing control to the datapath.
  typedef struct packed {
    logic bitValid;  // a data bit was decoded
    logic bitVal;    // its value
    logic sof;       // start-of-frame
    logic eod;       // end-of-data reached
    logic eof;       // end-of-frame gap reached
    logic symErr;    // invalid pulse width
  } symStrobe_t;
endpackage

// File: rtl/vpw_rx_ctrl.sv
module vpw_rx_ctrl
  import vpw_rx_pkg::*;
#(
  parameter int FILT_US   = 8,
  parameter int SHORT_MIN = 35,
  parameter int LONG_MIN  = 97,
  parameter int SOF_MIN   = 164,
  parameter int SOF_MAX   = 239,
  parameter int EOD_MIN   = 164,
  parameter int EOF_MIN   = 240
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tickUs,
  input  logic       rxLine,
  output symStrobe_t strobe
);
  localparam int FW    = $clog2(FILT_US);
  localparam int CNT_W = $clog2(EOF_MIN + 1) + 1;
  localparam logic [FW-1:0]    FILT_LAST = FW'(FILT_US - 1);
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W:0] SHORT_L = (CNT_W+1)'(SHORT_MIN);
  localparam logic [CNT_W:0] LONG_L  = (CNT_W+1)'(LONG_MIN);
  localparam logic [CNT_W:0] SOF_L   = (CNT_W+1)'(SOF_MIN);
  localparam logic [CNT_W:0] SOF_H   = (CNT_W+1)'(SOF_MAX);
  localparam logic [CNT_W:0] EOD_L   = (CNT_W+1)'(EOD_MIN);
  localparam logic [CNT_W:0] EOF_L   = (CNT_W+1)'(EOF_MIN);

  logic [1:0]       syncQ;
  logic             lineSync;
  logic             lineFilt;
  logic [FW-1:0]    filtCnt;
  logic [CNT_W-1:0] widthCnt;
  logic [CNT_W:0]   widthNow;
  logic             flipNow;
  symStrobe_t       strobeNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncQ <= '0;
    else        syncQ <= {syncQ[0], rxLine};
  end
  assign lineSync = syncQ[1];

  // Glitch filter: the line must differ for FILT_US ticks in a row.
  assign flipNow = tickUs && (lineSync != lineFilt) && (filtCnt == FILT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filtCnt  <= '0;
      lineFilt <= 1'b0;
    end else if (lineSync == lineFilt) begin
      filtCnt <= '0;
    end else if (tickUs) begin
      if (filtCnt == FILT_LAST) begin
        lineFilt <= lineSync;
        filtCnt  <= '0;
      end else begin
        filtCnt <= filtCnt + 1'b1;
      end
    end
  end

  // Width of the level in progress, in ticks, counting the current tick.
  assign widthNow = {1'b0, widthCnt} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            widthCnt <= '0;
    else if (flipNow)                      widthCnt <= '0;
    else if (tickUs && widthCnt != CNT_MAX) widthCnt <= widthCnt + 1'b1;
  end

  always_comb begin
    strobeNext = '0;
    if (flipNow) begin
      if (lineFilt) begin
        if (widthNow < SHORT_L)     strobeNext.symErr = 1'b1;
        else if (widthNow < LONG_L) begin strobeNext.bitValid = 1'b1; strobeNext.bitVal = 1'b1; end
        else if (widthNow < SOF_L)  begin strobeNext.bitValid = 1'b1; strobeNext.bitVal = 1'b0; end
        else if (widthNow <= SOF_H) strobeNext.sof = 1'b1;
        else                        strobeNext.symErr = 1'b1;
      end else begin
        if (widthNow < SHORT_L)     strobeNext.symErr = 1'b1;
        else if (widthNow < LONG_L) begin strobeNext.bitValid = 1'b1; strobeNext.bitVal = 1'b0; end
        else if (widthNow < EOD_L)  begin strobeNext.bitValid = 1'b1; strobeNext.bitVal = 1'b1; end
      end
    end
    if (tickUs && !lineFilt) begin
      if (widthNow == EOD_L) strobeNext.eod = 1'b1;
      if (widthNow == EOF_L) strobeNext.eof = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe <= '0;
    else        strobe <= strobeNext;
  end

  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.bitValid, strobe.sof, strobe.eod, strobe.eof, strobe.symErr}));

  // R1
  filt_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lineFilt != $past(lineFilt)) |-> $past(tickUs));

  // R3
  sof_after_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.sof |-> (!lineFilt && $past(lineFilt)));
endmodule

// File: rtl/vpw_rx_dp.sv
module vpw_rx_dp
  import vpw_rx_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] CRC_INIT = 8'hFF,
  parameter logic [DATA_W-1:0] CRC_POLY = 8'h1D,
  parameter logic [DATA_W-1:0] CRC_GOOD = 8'hC4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  symStrobe_t        strobe,
  input  logic              rdStrobe,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              timErr,
  output logic              crcErr,
  output logic              frameErr,
  output logic              frameEnd
);
  localparam int BW = $clog2(DATA_W);
  localparam logic [BW-1:0] BIT_LAST = BW'(DATA_W - 1);

  logic              inFrame;
  logic [BW-1:0]     bitCnt;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] crcReg;
  logic [DATA_W-1:0] crcNext;
  logic [DATA_W-1:0] newByte;
  logic [DATA_W-1:0] bufReg;
  logic              bufFull;
  logic [DATA_W-1:0] rxReg;
  logic              rxFull;
  logic              byteDone;

  assign crcNext  = {crcReg[DATA_W-2:0], 1'b0}
                  ^ ((crcReg[DATA_W-1] ^ strobe.bitVal) ? CRC_POLY : '0);
  assign newByte  = {shiftReg[DATA_W-2:0], strobe.bitVal};
  assign byteDone = strobe.bitValid && inFrame && (bitCnt == BIT_LAST);

  // Frame sequencing, bit assembly, CRC and sticky flags.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inFrame  <= 1'b0;
      bitCnt   <= '0;
      shiftReg <= '0;
      crcReg   <= CRC_INIT;
      timErr   <= 1'b0;
      crcErr   <= 1'b0;
      frameErr <= 1'b0;
    end else if (strobe.sof) begin
      inFrame  <= 1'b1;
      bitCnt   <= '0;
      crcReg   <= CRC_INIT;
      timErr   <= 1'b0;
      crcErr   <= 1'b0;
      frameErr <= 1'b0;
    end else if (strobe.symErr) begin
      timErr  <= 1'b1;
      inFrame <= 1'b0;
      bitCnt  <= '0;
    end else if (strobe.bitValid && inFrame) begin
      shiftReg <= newByte;
      crcReg   <= crcNext;
      bitCnt   <= byteDone ? '0 : bitCnt + 1'b1;
    end else if (strobe.eod && inFrame) begin
      inFrame <= 1'b0;
      bitCnt  <= '0;
      if (bitCnt != '0)            frameErr <= 1'b1;
      else if (crcReg != CRC_GOOD) crcErr   <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frameEnd <= 1'b0;
    else        frameEnd <= strobe.eof;
  end

  // Holding buffer feeding the receive register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bufReg  <= '0;
      bufFull <= 1'b0;
      rxReg   <= '0;
      rxFull  <= 1'b0;
    end else begin
      if (rdStrobe && rxFull) begin
        if (bufFull) begin
          rxReg   <= bufReg;
          bufFull <= 1'b0;
        end else begin
          rxFull <= 1'b0;
        end
      end else if (!rxFull && bufFull) begin
        rxReg   <= bufReg;
        rxFull  <= 1'b1;
        bufFull <= 1'b0;
      end
      if (byteDone) begin
        bufReg  <= newByte;
        bufFull <= 1'b1;
      end
    end
  end

  assign rxData  = rxReg;
  assign rxValid = rxFull;

  // R9
  rx_fill_from_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxFull) |-> $past(bufFull));

  // R9
  read_drains_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdStrobe && rxFull && !bufFull && !byteDone) |=> !rxFull);

  // R3
  sof_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.sof |=> (inFrame && !timErr && !crcErr && !frameErr && bitCnt == '0));

  // R8
  partial_eod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.eod && inFrame && bitCnt != '0 && !strobe.sof) |=> (frameErr && !inFrame));
endmodule

// File: rtl/vpw_rx.sv
module vpw_rx
  import vpw_rx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int FILT_US   = 8,
  parameter int SHORT_MIN = 35,
  parameter int LONG_MIN  = 97,
  parameter int SOF_MIN   = 164,
  parameter int SOF_MAX   = 239,
  parameter int EOD_MIN   = 164,
  parameter int EOF_MIN   = 240
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tickUs,
  input  logic              rxLine,
  input  logic              rdStrobe,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              symErrFlag,
  output logic              crcErrFlag,
  output logic              frameErrFlag,
  output logic              frameEnd
);
  symStrobe_t strobe;

  vpw_rx_ctrl #(
    .FILT_US(FILT_US), .SHORT_MIN(SHORT_MIN), .LONG_MIN(LONG_MIN),
    .SOF_MIN(SOF_MIN), .SOF_MAX(SOF_MAX), .EOD_MIN(EOD_MIN), .EOF_MIN(EOF_MIN)
  ) uCtrl (
    .clk(clk), .rst_n(rst_n), .tickUs(tickUs), .rxLine(rxLine), .strobe(strobe)
  );

  vpw_rx_dp #(
    .DATA_W(DATA_W)
  ) uDp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .rdStrobe(rdStrobe),
    .rxData(rxData), .rxValid(rxValid), .timErr(symErrFlag),
    .crcErr(crcErrFlag), .frameErr(frameErrFlag), .frameEnd(frameEnd)
  );
endmodule

// File: tb/tb_vpw_rx.sv
module tb_vpw_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tickUs = 1'b0;
  logic       rxLine = 1'b0;
  logic       rdStrobe = 1'b0;
  logic [7:0] rxData;
  logic       rxValid, symErrFlag, crcErrFlag, frameErrFlag, frameEnd;

  vpw_rx dut (
    .clk(clk), .rst_n(rst_n), .tickUs(tickUs), .rxLine(rxLine), .rdStrobe(rdStrobe),
    .rxData(rxData), .rxValid(rxValid), .symErrFlag(symErrFlag),
    .crcErrFlag(crcErrFlag), .frameErrFlag(frameErrFlag), .frameEnd(frameEnd)
  );

  always #2 clk = ~clk;

  int   checks = 0;
  int   errors = 0;
  int   reads = 0;
  int   eofCount = 0;
  bit   readEnable = 1'b1;
  bit   glitchPending = 1'b0;
  logic curLevel = 1'b0;
  logic [7:0] expQ[$];
  logic [7:0] msg[$];

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    tickUs = ~tickUs;
  end

  // Monitor side of the scoreboard: consume and compare bytes.
  initial forever begin
    @(negedge clk);
    if (readEnable && rxValid && !rdStrobe) begin
      reads++;
      if (expQ.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R9 unexpected byte actual %0d expected none", rxData);
      end else begin
        chk("R9 byte order", rxData, expQ.pop_front());
      end
      rdStrobe = 1'b1;
      @(negedge clk);
      rdStrobe = 1'b0;
    end
  end

  initial forever begin
    @(negedge clk);
    if (frameEnd) eofCount++;
  end

  initial begin
    repeat (190000) @(negedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [7:0] crc8(input logic [7:0] q[$]);
    logic [7:0] c = 8'hFF;
    foreach (q[i]) begin
      for (int b = 7; b >= 0; b--) begin
        logic fb = c[7] ^ q[i][b];
        c = {c[6:0], 1'b0} ^ (fb ? 8'h1D : 8'h00);
      end
    end
    return c;
  endfunction

  task automatic hold(input logic lvl, input int us);
    rxLine = lvl;
    repeat (2 * us) @(negedge clk);
  endtask

  task automatic sendBits(input logic [7:0] b, input int nbits, input int sw, input int lw);
    for (int i = 7; i > 7 - nbits; i--) begin
      int w = (curLevel ^ b[i]) ? lw : sw;
      if (glitchPending && !curLevel && w == lw) begin
        glitchPending = 1'b0;
        hold(1'b0, 60);
        hold(1'b1, 5);
        hold(1'b0, w - 65);
      end else begin
        hold(curLevel, w);
      end
      curLevel = ~curLevel;
    end
  endtask

  // Driver side: start-of-frame, bytes, expected values queued.
  task automatic sendFrame(input int sw, input int lw);
    hold(1'b1, 200);
    curLevel = 1'b0;
    foreach (msg[i]) begin
      expQ.push_back(msg[i]);
      sendBits(msg[i], 8, sw, lw);
    end
  endtask

  task automatic idle();
    hold(1'b0, 320);
    repeat (12) @(negedge clk);
  endtask

  task automatic goodMsg(input int sw, input int lw, input string tag);
    int e0 = eofCount;
    msg.push_back(~crc8(msg));
    reads = 0;
    sendFrame(sw, lw);
    idle();
    chk({tag, " bytes read"}, reads, msg.size());
    chk({tag, " queue drained"}, expQ.size(), 0);
    chk("R7 crc ok", crcErrFlag, 0);
    chk("R4 no timing error", symErrFlag, 0);
    chk("R6 one frameEnd", eofCount - e0, 1);
  endtask

  initial begin
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 rxValid", rxValid, 0);
    chk("R10 flags", {symErrFlag, crcErrFlag, frameErrFlag, frameEnd}, 0);
    idle();

    msg = {8'h68, 8'h6A, 8'hF1};
    goodMsg(64, 128, "R2 nominal");
    msg = {8'hA5, 8'h5A};
    goodMsg(35, 97, "R2 lower bounds");
    msg = {8'hFF, 8'h00};
    goodMsg(96, 163, "R2 upper bounds");

    msg = {8'h12, 8'h34};
    msg.push_back(~crc8(msg) ^ 8'h01);
    reads = 0;
    sendFrame(64, 128);
    idle();
    chk("R7 bad crc flagged", crcErrFlag, 1);
    chk("R7 bytes still delivered", reads, 3);

    glitchPending = 1'b1;
    msg = {8'h80};
    goodMsg(64, 128, "R1 glitch ignored");
    chk("R1 glitch consumed", glitchPending, 0);

    reads = 0;
    hold(1'b1, 200);
    hold(1'b0, 20);
    hold(1'b1, 64);
    idle();
    chk("R4 short pulse flagged", symErrFlag, 1);
    chk("R4 frame abandoned", reads, 0);
    chk("R4 no crc judgement", crcErrFlag, 0);

    msg = {8'h01};
    goodMsg(64, 128, "R3 new frame");
    chk("R3 flags cleared", symErrFlag, 0);

    hold(1'b1, 250);
    idle();
    chk("R4 long active flagged", symErrFlag, 1);

    reads = 0;
    hold(1'b1, 64);
    curLevel = 1'b0;
    sendBits(8'h3C, 8, 64, 128);
    idle();
    chk("R3 no byte without sof", reads, 0);

    reads = 0;
    hold(1'b1, 200);
    curLevel = 1'b0;
    sendBits(8'hB0, 4, 64, 128);
    idle();
    chk("R8 partial byte flagged", frameErrFlag, 1);
    chk("R8 partial byte dropped", reads, 0);
    chk("R8 no crc judgement", crcErrFlag, 0);

    msg = {8'h22};
    msg.push_back(~crc8(msg));
    reads = 0;
    sendFrame(64, 128);
    hold(1'b0, 170);
    curLevel = 1'b1;
    sendBits(8'h55, 8, 64, 128);
    idle();
    chk("R5 only framed bytes", reads, 2);
    chk("R5 crc judged at end of data", crcErrFlag, 0);

    // R9: sweep the read against the second byte's completion.
    for (int k = 8; k <= 26; k++) begin
      readEnable = 1'b0;
      reads = 0;
      msg = {8'h3C};
      msg.push_back(~crc8(msg));
      sendFrame(64, 128);
      rxLine = 1'b0;
      repeat (k) @(negedge clk);
      readEnable = 1'b1;
      idle();
      chk("R9 both bytes read", reads, 2);
      chk("R9 nothing left", expQ.size(), 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule